// File: doc/BRIEF.md
# Dual-Rate Avionics Serial Word Receiver

This block takes a bipolar return-to-zero serial line that has already been split into two logic-level inputs, `hiIn` and `loIn`. It recovers one bit from each pulse. It watches the idle time between pulses to find where each word begins and ends, and it assembles the bits into a word of 25 or 32 bits.

When the last bit of a word arrives, the block does three things in the same clock edge. It latches the word, stores the result of the parity check beside it, and raises `dataReady`. A host then reads the word as two 16-bit halves over `rdData`, picking the half with `selHalf` while `rdEn` is high. In the low half, the parity result takes the place of word bit 8.

Each bit cell lasts `BIT_CYCLES` clocks. A pulse fills the first half of the cell and the line is idle for the second half. The inputs are taken to be synchronous to `clk`.

Top module: `a429_rx`

## Requirements
- R1: A pulse on `hiIn` alone is a 1 bit and a pulse on `loIn` alone is a 0 bit. The level is sampled on the first registered clock of the pulse. The first bit received becomes word bit 0, and each later bit goes to the next higher position.
- R2: With `len32`=1 a word is 32 bits. With `len32`=0 a word is 25 bits, and bits 31..25 of the latched word read as 0.
- R3: Parity is counted over all bits of the word. With `parEven`=0 the check passes when the number of ones is odd. With `parEven`=1 it passes when the number of ones is even. The stored status is 1 for pass and 0 for fail.
- R4: When `rdEn`=1 and `selHalf`=0, `rdData` shows word bits 15..0, except that bit 8 carries the parity status. When `rdEn`=1 and `selHalf`=1, `rdData` shows word bits 31..16. When `rdEn`=0, `rdData` is 0.
- R5: `dataReady` rises on the clock edge that latches a word. That is the second edge after the input that carries the last bit's pulse is first driven.
- R6: `dataReady` falls on the clock edge after `rdEn` rises while `selHalf`=1. A rising `rdEn` with `selHalf`=0 leaves the flag set. If a word is latched on that same edge, the flag stays set.
- R7: A word that completes before the previous one has been read replaces it.
- R8: After 3*`BIT_CYCLES`+1 consecutive idle registered cycles, the bit count returns to 0 and any partial word is discarded. An idle run of exactly 3*`BIT_CYCLES` cycles keeps the partial word.
- R9: A pulse with both inputs high aborts the word in progress. All further pulses are ignored until an idle run as long as the one in R8 has been seen.
- R10: Out of reset, `dataReady`=0 and `rdData`=0. Pulses are ignored until the first idle run as long as the one in R8 has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hiIn | input | 1 | Line positive level, high during a 1 pulse |
| loIn | input | 1 | Line negative level, high during a 0 pulse |
| len32 | input | 1 | Word length: 1 = 32 bits, 0 = 25 bits |
| parEven | input | 1 | Parity sense: 0 = odd, 1 = even |
| rdEn | input | 1 | Read enable strobe |
| selHalf | input | 1 | Half select: 0 = low half with parity status, 1 = high half |
| rdData | output | 16 | Read data bus |
| dataReady | output | 1 | A latched word is waiting to be read |

## Verification
The clock edge that latches a new word can also be the edge that would clear `dataReady` after a high-half read. The bench provokes this by raising `rdEn` with `selHalf`=1 one clock after it drives the last pulse of a word. The latch then and the clear fall on the same edge. A correct design keeps `dataReady` set and returns the new word on the next two-part read. The bench's per-clock reference model and a directed check both judge that outcome.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int WORD_MAX   = 32;
  localparam int WORD_SHORT = 25;
  localparam int HALF_W     = WORD_MAX / 2;
  localparam int IDX_W      = $clog2(WORD_MAX);
  localparam int PAR_POS    = 8;

  typedef struct packed {
    logic             shift;
    logic             latch;
    logic             clear;
    logic             bitVal;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobe_t;
endpackage

// File: rtl/a429_rx_ctrl.sv
module a429_rx_ctrl
  import a429_rx_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hiIn,
  input  logic      loIn,
  input  logic      len32,
  input  logic      rdEn,
  input  logic      selHalf,
  output rxStrobe_t strobe,
  output logic      dataReady
);
  localparam int GAP_LIMIT = 3 * BIT_CYCLES + 1;
  localparam int IDLE_W    = $clog2(GAP_LIMIT + 1);

  logic             hiQ, loQ, actQ, enQ, waitGap;
  logic [IDX_W-1:0] bitCnt;
  logic [IDLE_W-1:0] idleCnt;

  logic             lineAct, lineIdle, pulseStart, gapHit, takeBit, badSym, readDone, lastBit;
  logic [IDX_W-1:0] lastIdx;

  assign lineAct    = hiQ | loQ;
  assign lineIdle   = ~lineAct;
  assign pulseStart = lineAct & ~actQ;
  assign gapHit     = lineIdle && (idleCnt == IDLE_W'(GAP_LIMIT - 1));
  assign takeBit    = pulseStart & ~waitGap;
  assign badSym     = hiQ & loQ;
  assign readDone   = rdEn & selHalf & ~enQ;
  assign lastIdx    = len32 ? IDX_W'(WORD_MAX - 1) : IDX_W'(WORD_SHORT - 1);
  assign lastBit    = (bitCnt >= lastIdx);

  always_comb begin
    strobe        = '0;
    strobe.bitVal = hiQ;
    strobe.bitIdx = bitCnt;
    if (gapHit) begin
      strobe.clear = 1'b1;
    end else if (takeBit) begin
      if (badSym)       strobe.clear = 1'b1;
      else if (lastBit) strobe.latch = 1'b1;
      else              strobe.shift = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ     <= 1'b0;
      loQ     <= 1'b0;
      actQ    <= 1'b0;
      enQ     <= 1'b0;
      waitGap <= 1'b1;
      bitCnt  <= '0;
      idleCnt <= '0;
    end else begin
      hiQ  <= hiIn;
      loQ  <= loIn;
      actQ <= lineAct;
      enQ  <= rdEn;
      if (lineIdle) begin
        if (idleCnt != IDLE_W'(GAP_LIMIT)) idleCnt <= idleCnt + 1'b1;
      end else begin
        idleCnt <= '0;
      end
      if (gapHit) begin
        bitCnt  <= '0;
        waitGap <= 1'b0;
      end else if (takeBit) begin
        if (badSym) begin
          bitCnt  <= '0;
          waitGap <= 1'b1;
        end else if (lastBit) begin
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataReady <= 1'b0;
    else if (strobe.latch) dataReady <= 1'b1;
    else if (readDone)     dataReady <= 1'b0;
  end

  p_latch_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> dataReady);
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && selHalf && !enQ && !strobe.latch) |=> !dataReady);
  p_abort_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (takeBit && badSym) |=> (waitGap && bitCnt == '0));
  p_gap_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    gapHit |=> (!waitGap && bitCnt == '0));
endmodule

// File: rtl/a429_rx_data.sv
module a429_rx_data
  import a429_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              parEven,
  input  logic              len32,
  input  logic              rdEn,
  input  logic              selHalf,
  output logic [HALF_W-1:0] rdData
);
  logic [WORD_MAX-1:0] acc, wordQ, newBit;
  logic                parAcc, parOk;
  logic [HALF_W-1:0]   lowHalf;

  assign newBit = WORD_MAX'(strobe.bitVal) << strobe.bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      parAcc <= 1'b0;
      wordQ  <= '0;
      parOk  <= 1'b0;
    end else if (strobe.latch) begin
      wordQ  <= acc | newBit;
      parOk  <= parAcc ^ strobe.bitVal ^ parEven;
      acc    <= '0;
      parAcc <= 1'b0;
    end else if (strobe.clear) begin
      acc    <= '0;
      parAcc <= 1'b0;
    end else if (strobe.shift) begin
      acc    <= acc | newBit;
      parAcc <= parAcc ^ strobe.bitVal;
    end
  end

  always_comb begin
    lowHalf          = wordQ[HALF_W-1:0];
    lowHalf[PAR_POS] = parOk;
    if (!rdEn)        rdData = '0;
    else if (selHalf) rdData = wordQ[WORD_MAX-1:HALF_W];
    else              rdData = lowHalf;
  end

  p_short_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && !len32) |=> (wordQ[WORD_MAX-1:WORD_SHORT] == '0));
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(wordQ));
endmodule

// File: rtl/a429_rx.sv
module a429_rx
  import a429_rx_pkg::*;
#(
  parameter int BIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiIn,
  input  logic              loIn,
  input  logic              len32,
  input  logic              parEven,
  input  logic              rdEn,
  input  logic              selHalf,
  output logic [HALF_W-1:0] rdData,
  output logic              dataReady
);
  rxStrobe_t strobe;

  a429_rx_ctrl #(.BIT_CYCLES(BIT_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .hiIn(hiIn), .loIn(loIn), .len32(len32),
    .rdEn(rdEn), .selHalf(selHalf), .strobe(strobe), .dataReady(dataReady)
  );

  a429_rx_data data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .parEven(parEven), .len32(len32),
    .rdEn(rdEn), .selHalf(selHalf), .rdData(rdData)
  );
endmodule

// File: tb/a429_rx_test.sv
`timescale 1ns/1ps
module a429_rx_test;
  localparam int BIT = 8;
  localparam int H   = BIT / 2;
  localparam int GAP = 3 * BIT + 1;

  logic clk = 0, rstN = 0, hiIn = 0, loIn = 0, len32 = 1, parEven = 0, rdEn = 0, selHalf = 0;
  logic [15:0] rdData;
  logic dataReady;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  a429_rx #(.BIT_CYCLES(BIT)) uut (
    .clk(clk), .rstN(rstN), .hiIn(hiIn), .loIn(loIn), .len32(len32), .parEven(parEven),
    .rdEn(rdEn), .selHalf(selHalf), .rdData(rdData), .dataReady(dataReady)
  );

  // behavioural reference model
  logic mH = 0, mL = 0, mPrevAct = 0, mEnPrev = 0, mWait = 1, mReady = 0, mPar = 0;
  logic [31:0] mWord = 0;
  int mIdle = 0;
  bit mBits[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mH = 0; mL = 0; mPrevAct = 0; mEnPrev = 0; mWait = 1; mReady = 0; mPar = 0;
      mWord = 0; mIdle = 0; mBits.delete();
    end else begin
      bit act, startB, gapB, clrB, latchB;
      int n, ones;
      act    = mH | mL;
      startB = act && !mPrevAct;
      gapB   = !act && (mIdle == GAP - 1);
      clrB   = rdEn && selHalf && !mEnPrev;
      latchB = 0;
      n      = len32 ? 32 : 25;
      if (gapB) begin
        mBits.delete(); mWait = 0;
      end else if (startB && !mWait) begin
        if (mH && mL) begin
          mBits.delete(); mWait = 1;
        end else begin
          mBits.push_back(mH);
          if (mBits.size() >= n) begin
            mWord = 0; ones = 0;
            foreach (mBits[i]) begin mWord[i] = mBits[i]; ones += mBits[i]; end
            mPar = (ones % 2 == 1) ^ parEven;
            latchB = 1;
            mBits.delete();
          end
        end
      end
      if (!act) begin if (mIdle != GAP) mIdle++; end else mIdle = 0;
      if (latchB) mReady = 1; else if (clrB) mReady = 0;
      mEnPrev = rdEn; mPrevAct = act; mH = hiIn; mL = loIn;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [15:0] e;
      e = 16'h0;
      if (rdEn) begin
        if (selHalf) e = mWord[31:16];
        else begin e = mWord[15:0]; e[8] = mPar; end
      end
      chk(dataReady === mReady, "R5 model ready", 32'(dataReady), 32'(mReady));
      chk(rdData === e, "R4 model data", 32'(rdData), 32'(e));
    end
  end

  function automatic logic [31:0] mkWord(input logic [31:0] p, input int n, input bit even);
    logic [31:0] w;
    w = (n == 32) ? p : (p & ((32'h1 << n) - 1));
    w[n-1] = 1'b0;
    w[n-1] = even ? ($countones(w) % 2 == 1) : ($countones(w) % 2 == 0);
    return w;
  endfunction

  task automatic sendBit(input bit b);
    hiIn = b; loIn = !b;
    repeat (H) @(negedge clk);
    hiIn = 0; loIn = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic sendErr();
    hiIn = 1; loIn = 1;
    repeat (H) @(negedge clk);
    hiIn = 0; loIn = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) sendBit(w[i]);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic readCheck(input logic [31:0] w, input bit pass, input string tag);
    logic [15:0] lo;
    lo = w[15:0]; lo[8] = pass;
    rdEn = 1; selHalf = 0;
    @(negedge clk);
    chk(rdData === lo, {tag, " R4 low half"}, 32'(rdData), 32'(lo));
    rdEn = 0;
    @(negedge clk);
    chk(dataReady === 1'b1, {tag, " R6 low read keeps ready"}, 32'(dataReady), 32'h1);
    rdEn = 1; selHalf = 1;
    @(negedge clk);
    chk(rdData === w[31:16], {tag, " R4 high half"}, 32'(rdData), 32'(w[31:16]));
    chk(dataReady === 1'b0, {tag, " R6 high read clears"}, 32'(dataReady), 32'h0);
    rdEn = 0; selHalf = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk(dataReady === 1'b0, "R10 reset ready", 32'(dataReady), 32'h0);
    chk(rdData === 16'h0, "R10 reset bus", 32'(rdData), 32'h0);
    rstN = 1;
    idle(2);
    // R10: pulses before first gap are ignored
    sendBits(mkWord(32'h1234_5678, 32, 0), 0, 31);
    chk(dataReady === 1'b0, "R10 ignored before gap", 32'(dataReady), 32'h0);
    idle(5 * BIT);

    // R1 R3: 32-bit odd parity, pass
    w = mkWord(32'hA5C3_0F91, 32, 0);
    sendBits(w, 0, 31);
    chk(dataReady === 1'b1, "R5 ready after word", 32'(dataReady), 32'h1);
    idle(5 * BIT);
    readCheck(w, 1, "R1 R3 odd pass");

    // R3 parity fail
    w = mkWord(32'h0F0F_1234, 32, 0) ^ 32'h1;
    sendBits(w, 0, 31); idle(5 * BIT);
    readCheck(w, 0, "R3 odd fail");

    // R3 even sense
    parEven = 1;
    w = mkWord(32'h7E11_BEEF, 32, 1);
    sendBits(w, 0, 31); idle(5 * BIT);
    readCheck(w, 1, "R3 even pass");
    parEven = 0;

    // R2 25-bit words
    len32 = 0;
    w = mkWord(32'h01FF_A0A0, 25, 0);
    sendBits(w, 0, 24); idle(5 * BIT);
    readCheck(w, 1, "R2 short word");
    len32 = 1;

    // R7 overwrite
    sendBits(mkWord(32'h1111_1111, 32, 0), 0, 31); idle(5 * BIT);
    w = mkWord(32'h2222_4444, 32, 0);
    sendBits(w, 0, 31); idle(5 * BIT);
    readCheck(w, 1, "R7 overwrite");

    // R8 long gap discards partial word
    sendBits(32'hFFFF_FFFF, 0, 9); idle(4 * BIT);
    w = mkWord(32'h3C3C_5A5A, 32, 0);
    sendBits(w, 0, 31); idle(5 * BIT);
    readCheck(w, 1, "R8 partial discarded");

    // R8 idle of exactly 3 bit times keeps partial word
    w = mkWord(32'h9876_1357, 32, 0);
    sendBits(w, 0, 15); idle(3 * BIT - H);
    sendBits(w, 16, 31); idle(5 * BIT);
    readCheck(w, 1, "R8 short gap kept");

    // R9 error symbol aborts, following pulses ignored
    sendBits(32'h0000_001F, 0, 4); sendErr();
    sendBits(32'hFFFF_FFFF, 0, 26);
    chk(dataReady === 1'b0, "R9 abort ignores bits", 32'(dataReady), 32'h0);
    idle(5 * BIT);
    w = mkWord(32'h6543_210F, 32, 0);
    sendBits(w, 0, 31); idle(5 * BIT);
    readCheck(w, 1, "R9 after abort");

    // R6 latch and high-half read rising on the same edge
    sendBits(mkWord(32'hAAAA_0001, 32, 0), 0, 31); idle(5 * BIT);
    w = mkWord(32'h5555_8002, 32, 0);
    sendBits(w, 0, 30);
    hiIn = w[31]; loIn = !w[31];
    @(negedge clk);
    rdEn = 1; selHalf = 1;
    repeat (H - 1) @(negedge clk);
    hiIn = 0; loIn = 0;
    repeat (H) @(negedge clk);
    rdEn = 0; selHalf = 0;
    @(negedge clk);
    chk(dataReady === 1'b1, "R6 latch wins over clear", 32'(dataReady), 32'h1);
    idle(5 * BIT);
    readCheck(w, 1, "R6 collided word");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R5 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule